// File: doc/BRIEF.md
# Two-Pin Power Mode Sequencer

This block turns two active-high power-control pins into one of three operating modes: power-down, power-save and normal operation. It also flags misuse of the pins. The first pin brings up the bias and configuration domain. The second pin brings up the main circuitry. At power-up the first pin must come up before the second.

The block drives these controls for the circuitry around it:

- a write enable for the configuration store, which opens only after a fixed settling time has passed since the first pin came up;
- a high-impedance control for the charge pump;
- an enable for the main circuit;
- a pair of flags that tell the configuration store whether to keep its contents or reload defaults.

The block runs from a free-running reference clock. The settling time is given in microseconds together with a cycles-per-microsecond parameter. The block counts bad pin combinations and bad orderings as a sticky fault. While the fault is set, every output stays at its power-down value. Only a return of both pins to low clears the fault.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block shows mode code 0, `core_en_o`=0, `wr_en_o`=0, `keep_cfg_o`=0, `cp_hiz_o`=1, `cfg_clear_o`=1 and `fault_o`=0.
- R2: Each pin passes through a two-flop synchronizer and then one output register. A pin change applied before a rising edge shows at the outputs after the third rising edge, and not after the second.
- R3: With both pins low the block shows mode code 0 (power-down), with `core_en_o`=0, `wr_en_o`=0, `keep_cfg_o`=0, `cp_hiz_o`=1 and `cfg_clear_o`=1.
- R4: With `pwr_a_i` high and `pwr_b_i` low the block shows mode code 1 (power-save), with `cp_hiz_o`=1, `core_en_o`=0, `keep_cfg_o`=1 and `cfg_clear_o`=0.
- R5: With both pins high, reached after `pwr_a_i` alone, the block shows mode code 2 (normal), with `core_en_o`=1, `cp_hiz_o`=0 and `keep_cfg_o`=1. Normal mode is only ever entered from power-save.
- R6: Let SETTLE = SETTLE_US*CYC_PER_US. `wr_en_o` is low through the (SETTLE+1)th rising edge after `pwr_a_i` goes high, and high from the (SETTLE+2)th edge on. It stays high while `pwr_a_i` stays high and no fault is set. While it is high, `keep_cfg_o` is also high.
- R7: Dropping `pwr_b_i` while in normal mode gives power-save with `keep_cfg_o`=1 and `cfg_clear_o`=0. `wr_en_o` stays high, so the configuration is retained.
- R8: Any visit to power-down clears the settling count. After `pwr_a_i` rises again, the full SETTLE delay of R6 applies again.
- R9: `pwr_a_i` low with `pwr_b_i` high is prohibited. It sets `fault_o`=1 and mode code 3, and holds `core_en_o`=0, `wr_en_o`=0, `keep_cfg_o`=0, `cp_hiz_o`=1 and `cfg_clear_o`=1.
- R10: Both pins going from low to high in the same synchronized sample is a sequencing violation and gives the same fault response as R9. Raising `pwr_a_i` first and `pwr_b_i` later gives no fault.
- R11: The fault is sticky. It stays set under any pin pattern except both low. Both pins low clear it and return the block to mode code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_a_i | input | 1 | First power-control pin (configuration and bias domain) |
| pwr_b_i | input | 1 | Second power-control pin (main circuitry) |
| mode_o | output | 2 | Mode code: 0 power-down, 1 power-save, 2 normal, 3 fault |
| core_en_o | output | 1 | Main circuit enable |
| cp_hiz_o | output | 1 | Charge pump output held high-impedance |
| wr_en_o | output | 1 | Configuration register write enable |
| keep_cfg_o | output | 1 | Configuration store keeps its contents |
| cfg_clear_o | output | 1 | Configuration store reloads defaults |
| fault_o | output | 1 | Sticky prohibited-state or sequencing fault |

## Verification
A corrupted mode register shows at once as a wrong mode code and a wrong set of enables, three edges after the pin change that should have set it. A settling counter that is off by one, or that is not cleared in power-down, moves the rise of `wr_en_o` by one or more cycles. The bench catches this because it samples on both sides of the exact edge where `wr_en_o` should rise. A fault latch that loses its state, or fails to set, shows within three edges as `core_en_o` rising under a prohibited pattern or `fault_o` falling while a pin is still high.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PM_OFF   = 2'd0,
        PM_SAVE  = 2'd1,
        PM_RUN   = 2'd2,
        PM_FAULT = 2'd3
    } pm_mode_e;

    // Registered control state of the sequencer.
    typedef struct packed {
        pm_mode_e   mode;
        logic       fault;
        logic [1:0] prev;   // last synchronized {b, a} sample
    } pm_state_t;

    localparam pm_state_t PM_STATE_RST = '{mode: PM_OFF, fault: 1'b0, prev: 2'b00};

endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] meta_d;
    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] hold_d;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_comb begin
                meta_d[i] = async_i[i];
                hold_d[i] = meta_q[i];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[i] <= 1'b0;
                    hold_q[i] <= 1'b0;
                end else begin
                    meta_q[i] <= meta_d[i];
                    hold_q[i] <= hold_d[i];
                end
            end
        end
    endgenerate

    assign sync_o = hold_q;

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             done_d, done_q;

    always_comb begin
        cnt_d  = '0;
        if (run_i) begin
            cnt_d = (cnt_q >= LIMIT_C) ? cnt_q : cnt_q + 1'b1;
        end
        done_d = run_i && (cnt_d >= LIMIT_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int SETTLE_US  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_a_i,
    input  logic       pwr_b_i,
    output logic [1:0] mode_o,
    output logic       core_en_o,
    output logic       cp_hiz_o,
    output logic       wr_en_o,
    output logic       keep_cfg_o,
    output logic       cfg_clear_o,
    output logic       fault_o
);

    localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;

    logic [1:0] pins_s;     // {b, a} after synchronization
    logic       a_s, b_s;
    logic       timer_run;
    pm_state_t  st_d, st_q;

    pwr_sync2 #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pwr_b_i, pwr_a_i}),
        .sync_o  (pins_s)
    );

    assign a_s = pins_s[0];
    assign b_s = pins_s[1];

    always_comb begin
        logic both_low;
        logic illegal;
        logic joint_rise;

        both_low   = !a_s && !b_s;
        illegal    = !a_s && b_s;
        joint_rise = (st_q.prev == 2'b00) && a_s && b_s;

        st_d       = st_q;
        st_d.prev  = pins_s;
        st_d.fault = (st_q.fault || illegal || joint_rise) && !both_low;

        if (st_d.fault) begin
            st_d.mode = PM_FAULT;
        end else if (both_low) begin
            st_d.mode = PM_OFF;
        end else if (b_s) begin
            st_d.mode = PM_RUN;
        end else begin
            st_d.mode = PM_SAVE;
        end

        timer_run = a_s && !st_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PM_STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    pwr_settle_timer #(.LIMIT(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .done_o (wr_en_o)
    );

    assign mode_o      = st_q.mode;
    assign fault_o     = st_q.fault;
    assign core_en_o   = (st_q.mode == PM_RUN);
    assign cp_hiz_o    = (st_q.mode != PM_RUN);
    assign keep_cfg_o  = (st_q.mode == PM_SAVE) || (st_q.mode == PM_RUN);
    assign cfg_clear_o = (st_q.mode == PM_OFF) || (st_q.mode == PM_FAULT);

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_o,
    input logic       core_en_o,
    input logic       cp_hiz_o,
    input logic       wr_en_o,
    input logic       keep_cfg_o,
    input logic       cfg_clear_o,
    input logic       fault_o
);

    a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!core_en_o && !wr_en_o && cp_hiz_o && !keep_cfg_o && cfg_clear_o));

    a_r5_run_from_save: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en_o) |-> ($past(mode_o) == 2'd1));

    a_r11_fault_exit_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o) |-> (mode_o == 2'd0));

    a_r6_write_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> keep_cfg_o);

    a_r3_off_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (!wr_en_o && !keep_cfg_o));

    a_r10_fault_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> (mode_o == 2'd3));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_o      (mode_o),
    .core_en_o   (core_en_o),
    .cp_hiz_o    (cp_hiz_o),
    .wr_en_o     (wr_en_o),
    .keep_cfg_o  (keep_cfg_o),
    .cfg_clear_o (cfg_clear_o),
    .fault_o     (fault_o)
);

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;

    localparam int CYC_PER_US = 250;
    localparam int SETTLE_US  = 50;
    localparam int SETTLE     = CYC_PER_US * SETTLE_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_a_i = 1'b0;
    logic       pwr_b_i = 1'b0;
    logic [1:0] mode_o;
    logic       core_en_o, cp_hiz_o, wr_en_o, keep_cfg_o, cfg_clear_o, fault_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_seq #(.CYC_PER_US(CYC_PER_US), .SETTLE_US(SETTLE_US)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_a_i     (pwr_a_i),
        .pwr_b_i     (pwr_b_i),
        .mode_o      (mode_o),
        .core_en_o   (core_en_o),
        .cp_hiz_o    (cp_hiz_o),
        .wr_en_o     (wr_en_o),
        .keep_cfg_o  (keep_cfg_o),
        .cfg_clear_o (cfg_clear_o),
        .fault_o     (fault_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Wait n rising edges, then step off the edge before sampling.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        pwr_a_i = a;
        pwr_b_i = b;
    endtask

    task automatic expect_off(input string req);
        check(req, "mode", mode_o, 0);
        check(req, "core_en", core_en_o, 0);
        check(req, "wr_en", wr_en_o, 0);
        check(req, "keep_cfg", keep_cfg_o, 0);
        check(req, "cp_hiz", cp_hiz_o, 1);
        check(req, "cfg_clear", cfg_clear_o, 1);
    endtask

    task automatic expect_fault(input string req);
        check(req, "fault", fault_o, 1);
        check(req, "mode", mode_o, 3);
        check(req, "core_en", core_en_o, 0);
        check(req, "wr_en", wr_en_o, 0);
        check(req, "keep_cfg", keep_cfg_o, 0);
        check(req, "cp_hiz", cp_hiz_o, 1);
        check(req, "cfg_clear", cfg_clear_o, 1);
    endtask

    task automatic t_reset;
        step(1);
        expect_off("R1");
        check("R1", "fault", fault_o, 0);
    endtask

    task automatic t_save_and_settle;
        drive(1'b1, 1'b0);
        step(2);
        check("R2", "mode before third edge", mode_o, 0);
        step(1);
        check("R4", "mode", mode_o, 1);
        check("R4", "cp_hiz", cp_hiz_o, 1);
        check("R4", "core_en", core_en_o, 0);
        check("R4", "keep_cfg", keep_cfg_o, 1);
        check("R4", "cfg_clear", cfg_clear_o, 0);
        check("R6", "wr_en early", wr_en_o, 0);
        step(SETTLE - 2);
        check("R6", "wr_en at SETTLE+1", wr_en_o, 0);
        step(1);
        check("R6", "wr_en at SETTLE+2", wr_en_o, 1);
        step(20);
        check("R6", "wr_en held", wr_en_o, 1);
    endtask

    task automatic t_normal;
        drive(1'b1, 1'b1);
        step(3);
        check("R5", "mode", mode_o, 2);
        check("R5", "core_en", core_en_o, 1);
        check("R5", "cp_hiz", cp_hiz_o, 0);
        check("R5", "keep_cfg", keep_cfg_o, 1);
        check("R10", "no fault on ordered rise", fault_o, 0);
    endtask

    task automatic t_retention;
        drive(1'b1, 1'b0);
        step(3);
        check("R7", "mode", mode_o, 1);
        check("R7", "keep_cfg", keep_cfg_o, 1);
        check("R7", "cfg_clear", cfg_clear_o, 0);
        check("R7", "wr_en kept", wr_en_o, 1);
    endtask

    task automatic t_powerdown_restart;
        drive(1'b0, 1'b0);
        step(3);
        expect_off("R3");
        drive(1'b1, 1'b0);
        step(3);
        check("R8", "wr_en after restart", wr_en_o, 0);
        step(SETTLE - 2);
        check("R8", "wr_en at SETTLE+1", wr_en_o, 0);
        step(1);
        check("R8", "wr_en at SETTLE+2", wr_en_o, 1);
        drive(1'b0, 1'b0);
        step(3);
        expect_off("R3");
    endtask

    task automatic t_prohibited;
        drive(1'b0, 1'b1);
        step(3);
        expect_fault("R9");
        drive(1'b1, 1'b1);
        step(3);
        expect_fault("R11");
        drive(1'b1, 1'b0);
        step(3);
        expect_fault("R11");
        drive(1'b0, 1'b0);
        step(3);
        check("R11", "fault cleared", fault_o, 0);
        expect_off("R11");
    endtask

    task automatic t_joint_rise;
        drive(1'b1, 1'b1);
        step(3);
        expect_fault("R10");
        step(SETTLE + 5);
        check("R10", "wr_en held off", wr_en_o, 0);
        check("R11", "fault still set", fault_o, 1);
        drive(1'b0, 1'b0);
        step(3);
        check("R11", "fault cleared", fault_o, 0);
        check("R11", "mode", mode_o, 0);
    endtask

    task automatic t_ordered_rise;
        drive(1'b1, 1'b0);
        step(3);
        drive(1'b1, 1'b1);
        step(3);
        check("R10", "ordered fault", fault_o, 0);
        check("R5", "mode", mode_o, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_save_and_settle();
        t_normal();
        t_retention();
        t_powerdown_restart();
        t_prohibited();
        t_joint_rise();
        t_ordered_rise();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule